// File: doc/BRIEF.md
# Filtered Digital Lock Detector

This block watches the up and down pulses of a phase-frequency detector and
reports whether the loop is locked. A fast sampling clock measures how wide the
phase error is during each comparison cycle. A single-cycle comparison strobe
marks the end of each cycle. The error width is the number of sampling clocks
in which at least one of the two pulses is high.

The lock flag has asymmetric hysteresis. A run of consecutive cycles with a
small error is needed before lock is declared. One cycle with a large error
drops it. An error between the two thresholds leaves the flag as it is. A
power-down input forces the flag low at once and discards all progress toward
lock, so a new lock needs a full new run of good cycles. Both thresholds and the
run length are parameters counted in sampling-clock cycles.

Top module: `pfd_lock_detect`

## Requirements
- R1: A comparison cycle is good when its error width is below ACQ_TH (15). The flag rises at the strobe that ends the GOOD_CYCLES-th (5th) good cycle in a row, and not before.
- R2: A cycle whose error width is above LOSE_TH (30) clears the flag at the strobe that ends it. A width of exactly 30 does not clear it.
- R3: A width from ACQ_TH to LOSE_TH inclusive (15 to 30) leaves the flag unchanged.
- R4: While pwr_down is 1, lock_out is 0 in the same cycle.
- R5: Any cycle with a width of ACQ_TH or more restarts the run of good cycles, so GOOD_CYCLES further good cycles are needed.
- R6: While pwr_down is 1, the good-cycle run, the flag and the width being measured are all cleared. After pwr_down returns to 0, lock needs GOOD_CYCLES new good cycles.
- R7: The error width counts sampling clocks in which pulse_up or pulse_dn is 1. The count runs from the clock after the previous strobe up to and including the strobe clock. A clock with both pulses high counts once. Widths above LOSE_TH saturate and still count as large.
- R8: lock_out changes only in the clock that follows a sampled strobe, a pwr_down change or a reset.
- R9: After reset, lock_out is 0 and the good-cycle run is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_up | input | 1 | Up pulse from the phase detector |
| pulse_dn | input | 1 | Down pulse from the phase detector |
| cmp_strobe | input | 1 | One-clock strobe that ends a comparison cycle |
| pwr_down | input | 1 | Loop power-down; forces the flag low |
| lock_out | output | 1 | Filtered lock indication |

## Verification
The error pulses are driven in four shapes: up only, down only, both pulses high
together, and up followed by down. The overlapping shape shows whether a clock
is counted once or twice. The split shape shows whether the two pulses are
combined. Widths are placed on both sides of 15 and 30 to test each comparison
for an off-by-one error. Runs of four and five good cycles are broken by a
middle-band cycle or by power-down, which shows whether the run is really
restarted. A sample taken just before each strobe shows whether the flag moves
before the strobe.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    typedef enum logic [1:0] {
        CLS_GOOD = 2'd0,
        CLS_HOLD = 2'd1,
        CLS_BAD  = 2'd2
    } err_class_e;
endpackage

// File: rtl/lockdet_width_meter.sv
module lockdet_width_meter #(
    parameter int SAT = 31,
    parameter int CW  = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse_up,
    input  logic          pulse_dn,
    input  logic          cmp_strobe,
    input  logic          pwr_down,
    output logic [CW-1:0] width_total
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    typedef struct packed {
        logic [CW-1:0] acc;
    } meter_t;

    meter_t st_d, st_q;
    logic   active;

    always_comb begin
        active = pulse_up | pulse_dn;
        if (active && st_q.acc != SAT_V) width_total = st_q.acc + 1'b1;
        else                             width_total = st_q.acc;
        st_d = st_q;
        if (pwr_down || cmp_strobe) st_d.acc = '0;
        else                        st_d.acc = width_total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: an active clock between strobes adds exactly one to the running width
    assert_width_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_strobe && !pwr_down && (pulse_up || pulse_dn) && st_q.acc < SAT_V)
        |=> st_q.acc == $past(st_q.acc) + 1'b1);

    // R7: the running width never exceeds the saturation value
    assert_width_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc <= SAT_V);
endmodule

// File: rtl/lockdet_classifier.sv
module lockdet_classifier
    import lockdet_pkg::*;
#(
    parameter int ACQ_TH  = 15,
    parameter int LOSE_TH = 30,
    parameter int CW      = $clog2(LOSE_TH + 2)
) (
    input  logic [CW-1:0] width,
    output err_class_e    cls
);
    localparam logic [CW-1:0] ACQ_V  = CW'(ACQ_TH);
    localparam logic [CW-1:0] LOSE_V = CW'(LOSE_TH);

    always_comb begin
        if (width < ACQ_V)       cls = CLS_GOOD;
        else if (width > LOSE_V) cls = CLS_BAD;
        else                     cls = CLS_HOLD;
    end

    initial begin
        assert_thresh_order_R3: assert (ACQ_TH <= LOSE_TH);
    end
endmodule

// File: rtl/lockdet_hyst.sv
module lockdet_hyst
    import lockdet_pkg::*;
#(
    parameter int GOOD_CYCLES = 5,
    parameter int GW          = $clog2(GOOD_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_strobe,
    input  logic       pwr_down,
    input  err_class_e cls,
    output logic       locked
);
    localparam logic [GW-1:0] GOOD_V = GW'(GOOD_CYCLES);

    typedef struct packed {
        logic [GW-1:0] good_cnt;
        logic          lock;
    } hyst_t;

    hyst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_down) begin
            st_d.good_cnt = '0;
            st_d.lock     = 1'b0;
        end else if (cmp_strobe) begin
            unique case (cls)
                CLS_GOOD: begin
                    if (st_q.good_cnt != GOOD_V)
                        st_d.good_cnt = st_q.good_cnt + 1'b1;
                    if (st_q.good_cnt >= GOOD_V - 1'b1)
                        st_d.lock = 1'b1;
                end
                CLS_HOLD: st_d.good_cnt = '0;
                default: begin
                    st_d.good_cnt = '0;
                    st_d.lock     = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;

    // R1: lock can only rise on a good strobe that completes the run
    assert_lock_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> ($past(cmp_strobe) && $past(cls) == CLS_GOOD
                              && $past(st_q.good_cnt) == GOOD_V - 1'b1));

    // R2: a large-error strobe always leaves the flag low
    assert_lock_lose_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_strobe && !pwr_down && cls == CLS_BAD) |=> !st_q.lock);

    // R6: power-down leaves no progress toward lock
    assert_pd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (st_q.good_cnt == '0 && !st_q.lock));

    // R8: without strobe or power-down the flag holds
    assert_lock_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_strobe && !pwr_down) |=> $stable(st_q.lock));

    // R5: the good run never exceeds its target
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.good_cnt <= GOOD_V);
endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
    import lockdet_pkg::*;
#(
    parameter int ACQ_TH      = 15,
    parameter int LOSE_TH     = 30,
    parameter int GOOD_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_up,
    input  logic pulse_dn,
    input  logic cmp_strobe,
    input  logic pwr_down,
    output logic lock_out
);
    localparam int SAT = LOSE_TH + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] width_total;
    err_class_e    cls;
    logic          locked;

    lockdet_width_meter #(.SAT(SAT), .CW(CW)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_up   (pulse_up),
        .pulse_dn   (pulse_dn),
        .cmp_strobe (cmp_strobe),
        .pwr_down   (pwr_down),
        .width_total(width_total)
    );

    lockdet_classifier #(.ACQ_TH(ACQ_TH), .LOSE_TH(LOSE_TH), .CW(CW)) u_cls (
        .width(width_total),
        .cls  (cls)
    );

    lockdet_hyst #(.GOOD_CYCLES(GOOD_CYCLES)) u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_strobe(cmp_strobe),
        .pwr_down  (pwr_down),
        .cls       (cls),
        .locked    (locked)
    );

    assign lock_out = locked & ~pwr_down;

    // R4: power-down forces the output low in the same cycle
    assert_pd_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !lock_out);
endmodule

// File: tb/tb_pfd_lock_detect.sv
module tb_pfd_lock_detect;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_LEN    = 40;
    localparam int NV         = 18;

    // {width, pattern, expected lock after strobe}
    // pattern 0 up only, 1 down only, 2 both overlapped, 3 up then down
    localparam int VEC [NV][3] = '{
        '{10, 0, 0}, '{14, 1, 0}, '{0, 0, 0}, '{5, 2, 0}, '{14, 3, 1},
        '{20, 0, 1}, '{30, 1, 1}, '{31, 0, 0},
        '{1, 2, 0}, '{1, 0, 0}, '{1, 1, 0}, '{15, 0, 0},
        '{2, 3, 0}, '{3, 2, 0}, '{4, 1, 0}, '{13, 0, 0}, '{12, 3, 1},
        '{35, 3, 0}
    };
    localparam string VTAG [NV] = '{
        "R1", "R1", "R1", "R7", "R1", "R3", "R2", "R2",
        "R5", "R5", "R5", "R5", "R5", "R7", "R5", "R5", "R5", "R7"
    };

    logic clk = 0, rst_n = 0;
    logic pulse_up = 0, pulse_dn = 0, cmp_strobe = 0, pwr_down = 0;
    logic lock_out;
    int   checks = 0, failures = 0;
    logic prev_lock = 0;
    bit   done = 0;

    pfd_lock_detect dut (
        .clk(clk), .rst_n(rst_n), .pulse_up(pulse_up), .pulse_dn(pulse_dn),
        .cmp_strobe(cmp_strobe), .pwr_down(pwr_down), .lock_out(lock_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s lock_out actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // one comparison cycle of CYC_LEN clocks, strobe on the last
    task automatic comp_cycle(input int w, input int pat, input logic pd,
                              input string tag, input logic exp);
        for (int k = 0; k < CYC_LEN; k++) begin
            @(negedge clk);
            if (k == CYC_LEN - 1 && !pd) check("R8", lock_out, prev_lock);
            pwr_down   = pd;
            cmp_strobe = (k == CYC_LEN - 1);
            case (pat)
                0: begin pulse_up = (k < w); pulse_dn = 0; end
                1: begin pulse_up = 0; pulse_dn = (k < w); end
                2: begin pulse_up = (k < w); pulse_dn = (k < w); end
                default: begin pulse_up = (k < w/2); pulse_dn = (k >= w/2 && k < w); end
            endcase
        end
        @(negedge clk);
        cmp_strobe = 0; pulse_up = 0; pulse_dn = 0;
        check(tag, lock_out, exp);
        prev_lock = exp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", lock_out, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check("R9", lock_out, 1'b0);

        for (int i = 0; i < NV; i++)
            comp_cycle(VEC[i][0], VEC[i][1], 1'b0, VTAG[i], VEC[i][2] != 0);

        // a large error while unlocked keeps the flag low
        comp_cycle(40, 0, 1'b0, "R2", 1'b0);

        // lock up, then power down mid-cycle
        for (int i = 0; i < 5; i++) comp_cycle(3, 0, 1'b0, "R1", i == 4);
        @(negedge clk); pwr_down = 1; pulse_up = 1;
        #1 check("R4", lock_out, 1'b0);
        @(negedge clk); check("R4", lock_out, 1'b0);
        pwr_down = 0; pulse_up = 0;
        @(negedge clk); check("R6", lock_out, 1'b0);
        prev_lock = 0;

        // four goods, a powered-down good cycle, then five fresh goods
        for (int i = 0; i < 4; i++) comp_cycle(2, 2, 1'b0, "R6", 1'b0);
        comp_cycle(2, 0, 1'b1, "R6", 1'b0);
        pwr_down = 0;
        for (int i = 0; i < 4; i++) comp_cycle(2, 1, 1'b0, "R6", 1'b0);
        comp_cycle(2, 1, 1'b0, "R6", 1'b1);

        // reset while locked
        @(negedge clk); rst_n = 0;
        #1 check("R9", lock_out, 1'b0);
        @(negedge clk); rst_n = 1; prev_lock = 0;
        comp_cycle(1, 0, 1'b0, "R9", 1'b0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule